// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether a received Ethernet frame addressed to a multicast group should be kept. It sees the six destination-address bytes one at a time. A start strobe marks the first byte and a valid strobe marks each byte. Over those bytes it runs the reflected Ethernet CRC-32. The upper six bits of the inverted result form an index into a 64-bit hash table. Software programs that table as two 32-bit words, plus a separate enable bit for multicast acceptance.

One cycle after the sixth byte is taken, the block raises a single-cycle done pulse. With it come two flags: one saying whether the address was a group address (bit 0 of the first byte set), and one giving the accept verdict. When the first byte marks an individual address, the block reports it as not multicast and never accepts it. The table and the enable bit are copied into a private snapshot when each address starts. A configuration write that lands while an address is in flight therefore only affects the next address.

The controller is a three-state machine:
- `ST_IDLE` waits for a start byte.
- `ST_COLLECT` folds bytes two to six into the CRC.
- `ST_REPORT` is the single cycle in which the verdict is shown.

Its transitions are:
- **begin** (`ST_IDLE` to `ST_COLLECT` on a start byte).
- **restart** (`ST_COLLECT` to `ST_COLLECT` on a start byte, which aborts the address in progress).
- **finish** (`ST_COLLECT` to `ST_REPORT` when the sixth byte is taken).
- **chain** (`ST_REPORT` to `ST_COLLECT` on a start byte).
- **settle** (`ST_REPORT` to `ST_IDLE` otherwise).

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset `dec_done`, `dec_mcast` and `dec_accept` are 0, both table words are 0 and the enable bit is 0, so no address is accepted until software programs the filter.
- R2: The hash is a CRC-32 with the reflected polynomial 0xEDB88320, shifted right. It starts from 0xFFFFFFFF and takes each byte least-significant bit first, in arrival order. The result is inverted, and the index is bits 31..26 of the inverted result.
- R3: Index bit 5 picks the table word (0 = word written with `cfg_sel`=0, 1 = word written with `cfg_sel`=1). Index bits 4..0 pick the bit inside that word. `dec_accept` is 1 exactly when that bit is 1, the enable bit is 1, and the address is a group address.
- R4: With the enable bit at 0, every address is rejected whatever the table holds.
- R5: With both words all ones and the enable bit at 1, every group address is accepted.
- R6: If bit 0 of the first byte is 0, the report shows `dec_mcast`=0 and `dec_accept`=0. `dec_accept` is never 1 without `dec_mcast`, and `dec_mcast` is never 1 without `dec_done`.
- R7: A byte is taken on a rising edge where `addr_valid` is 1. `dec_done` is a one-cycle pulse in the cycle right after the sixth byte of an address is taken, and it is 0 at all other times.
- R8: A byte taken with `addr_start`=1 while an address is in progress discards the earlier bytes. That byte becomes byte one of a new address.
- R9: A byte with `addr_valid`=1 and `addr_start`=0 while no address is in progress is ignored. `addr_start` without `addr_valid` is ignored. Cycles with `addr_valid`=0 between the bytes of an address are allowed and change nothing.
- R10: A write with `cfg_we`=1 behaves according to `cfg_sel`:
  - `cfg_sel`=0 loads table word 0 from `cfg_wdata`.
  - `cfg_sel`=1 loads table word 1 from `cfg_wdata`.
  - `cfg_sel`=2 loads the enable bit from `cfg_wdata[0]`.
  - `cfg_sel`=3 has no effect.
  
  The configuration is captured when the start byte is taken. A write on that same edge or later only applies to the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_start | input | 1 | Marks the byte as the first of an address (qualified by `addr_valid`) |
| addr_valid | input | 1 | A destination-address byte is present |
| addr_byte | input | 8 | Destination-address byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 word 0, 1 word 1, 2 enable, 3 none |
| cfg_wdata | input | 32 | Write data |
| dec_done | output | 1 | Verdict valid this cycle |
| dec_mcast | output | 1 | Address was a group address |
| dec_accept | output | 1 | Frame accepted by the hash filter |

## Verification
Random addresses are run against random tables and enable settings, with random idle gaps between bytes. The expected verdict comes from a bit-serial CRC model. This exposes a wrong polynomial, bit order, seed or final inversion, because each of these moves the index. A table holding only one bit, first in the right word and then in the wrong word at the same bit position, separates the word select from the bit select. All-ones and all-zeros tables with the enable bit flipped isolate the enable. Further cases cover:
- an address cut short by a new start;
- stray bytes sent while idle;
- configuration writes landing on and after the start byte, which show whether the snapshot is taken at the right edge.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } mhf_state_e;

    localparam int unsigned     CRC_W         = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFFFFFF;

endpackage

// File: rtl/mhf_crc_step.sv
// One byte of the reflected CRC, least-significant bit first.
module mhf_crc_step #(
    parameter int unsigned      CW   = 32,
    parameter int unsigned      DW   = 8,
    parameter logic [CW-1:0]    POLY = 32'hEDB88320
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] crc_out
);

    always_comb begin
        logic [CW-1:0] acc;
        acc = crc_in ^ {{(CW-DW){1'b0}}, data_in};
        for (int k = 0; k < DW; k++) begin
            if (acc[0]) acc = (acc >> 1) ^ POLY;
            else        acc = acc >> 1;
        end
        crc_out = acc;
    end

endmodule

// File: rtl/mhf_cfg_regs.sv
// Live filter configuration plus the per-address snapshot.
module mhf_cfg_regs #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NWORDS = 2,
    parameter int unsigned SEL_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [WORD_W-1:0]        cfg_wdata,
    input  logic                     snap_take,
    output logic [NWORDS*WORD_W-1:0] snap_table,
    output logic                     snap_en
);

    localparam int unsigned TBL_W = NWORDS * WORD_W;

    logic [TBL_W-1:0] live_table;
    logic             live_en;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(w))
                word_q <= cfg_wdata;
        end
        assign live_table[w*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_en <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_W'(NWORDS))
            live_en <= cfg_wdata[0];
    end

    // Snapshot takes the pre-write value on the start edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_table <= '0;
            snap_en    <= 1'b0;
        end else if (snap_take) begin
            snap_table <= live_table;
            snap_en    <= live_en;
        end
    end

endmodule

// File: rtl/mhf_ctrl.sv
// Address sequencer: byte counting, CRC accumulation and verdict output.
module mhf_ctrl
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_LEN  = 6,
    parameter int unsigned DW        = 8,
    parameter int unsigned HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_start,
    input  logic                 addr_valid,
    input  logic [DW-1:0]        addr_byte,
    input  logic                 tbl_hit,
    input  logic                 grp_en,
    output logic                 snap_take,
    output logic [HASH_BITS-1:0] hash_idx,
    output logic                 dec_done,
    output logic                 dec_mcast,
    output logic                 dec_accept
);

    localparam int unsigned CNT_W = $clog2(ADDR_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_LEN - 1);

    mhf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q, crc_seed, crc_next;
    logic             group_q;
    logic             start_byte, cont_byte, last_byte;

    assign start_byte = addr_valid && addr_start;
    assign cont_byte  = addr_valid && !addr_start && (state_q == ST_COLLECT);
    assign last_byte  = cont_byte && (cnt_q == LAST_CNT);
    assign snap_take  = start_byte;
    assign crc_seed   = start_byte ? CRC_SEED : crc_q;

    mhf_crc_step #(
        .CW   (CRC_W),
        .DW   (DW),
        .POLY (CRC_POLY_REFL)
    ) u_step (
        .crc_in  (crc_seed),
        .data_in (addr_byte),
        .crc_out (crc_next)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: begin, restart, finish, chain, settle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_byte) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (start_byte)     state_d = ST_COLLECT;
                else if (last_byte) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                if (start_byte) state_d = ST_COLLECT;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            crc_q   <= CRC_SEED;
            group_q <= 1'b0;
        end else if (start_byte) begin
            cnt_q   <= CNT_W'(1);
            crc_q   <= crc_next;
            group_q <= addr_byte[0];
        end else if (cont_byte) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            crc_q   <= crc_next;
        end
    end

    // Final inversion folded into the index tap.
    assign hash_idx = ~crc_q[CRC_W-1 -: HASH_BITS];

    // Outputs.
    always_comb begin
        dec_done   = 1'b0;
        dec_mcast  = 1'b0;
        dec_accept = 1'b0;
        unique case (state_q)
            ST_REPORT: begin
                dec_done   = 1'b1;
                dec_mcast  = group_q;
                dec_accept = group_q && grp_en && tbl_hit;
            end
            ST_IDLE, ST_COLLECT: begin
                dec_done = 1'b0;
            end
            default: dec_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int unsigned ADDR_LEN  = 6,
    parameter int unsigned HASH_BITS = 6,
    parameter int unsigned WORD_W    = 32
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              addr_start,
    input  logic                                              addr_valid,
    input  logic [7:0]                                        addr_byte,
    input  logic                                              cfg_we,
    input  logic [$clog2(((1 << HASH_BITS) / WORD_W) + 1)-1:0] cfg_sel,
    input  logic [WORD_W-1:0]                                 cfg_wdata,
    output logic                                              dec_done,
    output logic                                              dec_mcast,
    output logic                                              dec_accept
);

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TBL_W  = 1 << HASH_BITS;
    localparam int unsigned NWORDS = TBL_W / WORD_W;
    localparam int unsigned SEL_W  = $clog2(NWORDS + 1);

    logic [TBL_W-1:0]     snap_table;
    logic                 snap_en;
    logic                 snap_take;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 tbl_hit;

    mhf_cfg_regs #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS),
        .SEL_W  (SEL_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .snap_take  (snap_take),
        .snap_table (snap_table),
        .snap_en    (snap_en)
    );

    // Upper index bits select the word, lower bits the bit within it.
    assign tbl_hit = snap_table[hash_idx];

    mhf_ctrl #(
        .ADDR_LEN  (ADDR_LEN),
        .DW        (BYTE_W),
        .HASH_BITS (HASH_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_start (addr_start),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .tbl_hit    (tbl_hit),
        .grp_en     (snap_en),
        .snap_take  (snap_take),
        .hash_idx   (hash_idx),
        .dec_done   (dec_done),
        .dec_mcast  (dec_mcast),
        .dec_accept (dec_accept)
    );

endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_valid,
    input logic dec_done,
    input logic dec_mcast,
    input logic dec_accept
);

    assert_done_follows_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |-> $past(addr_valid));

    assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);

    assert_accept_needs_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> (dec_mcast && dec_done));

    assert_group_flag_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_mcast |-> dec_done);

endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .dec_done   (dec_done),
    .dec_mcast  (dec_mcast),
    .dec_accept (dec_accept)
);

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_start = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_done, dec_mcast, dec_accept;

    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] m_tbl = '0;
    logic        m_en  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter u_mcast_hash_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_start (addr_start),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .dec_done   (dec_done),
        .dec_mcast  (dec_mcast),
        .dec_accept (dec_accept)
    );

    // R2 model: bit-serial reflected CRC, inverted, top six bits.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            c = c ^ {24'h0, a[8*i +: 8]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        return c[31:26];
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [31:0] d);
        case (s)
            2'd0: m_tbl[31:0]  = d;
            2'd1: m_tbl[63:32] = d;
            2'd2: m_en         = d[0];
            default: ;
        endcase
    endtask

    task automatic check_v(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {done,mcast,accept} got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        model_write(s, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_table(input logic [63:0] t);
        cfg_write(2'd0, t[31:0]);
        cfg_write(2'd1, t[63:32]);
    endtask

    // Sends one six-byte address; optional write on byte wr_at.
    task automatic send_addr(input logic [47:0] a, input int gap_max, input int wr_at,
                             input logic [1:0] wsel, input logic [31:0] wdata, input string tag);
        logic [63:0] s_tbl;
        logic        s_en;
        logic [5:0]  ix;
        logic        exp_acc;
        s_tbl = m_tbl;
        s_en  = m_en;
        for (int i = 0; i < 6; i++) begin
            int g;
            g = (i > 0 && gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
            for (int j = 0; j < g; j++) begin
                @(negedge clk);
                addr_valid = 1'b0; addr_start = 1'b0; cfg_we = 1'b0;
                check_v({tag, " R9 gap"}, {dec_done, dec_mcast, dec_accept}, 3'b000);
            end
            @(negedge clk);
            if (i > 0)
                check_v({tag, " R7 early"}, {dec_done, dec_mcast, dec_accept}, 3'b000);
            if (i == 0) begin
                s_tbl = m_tbl;
                s_en  = m_en;
            end
            addr_valid = 1'b1;
            addr_start = (i == 0);
            addr_byte  = a[8*i +: 8];
            if (i == wr_at) begin
                cfg_we = 1'b1; cfg_sel = wsel; cfg_wdata = wdata;
                model_write(wsel, wdata);
            end else begin
                cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        addr_valid = 1'b0; addr_start = 1'b0; cfg_we = 1'b0;
        ix      = ref_idx(a);
        exp_acc = a[0] & s_en & s_tbl[ix];
        check_v(tag, {dec_done, dec_mcast, dec_accept}, {1'b1, a[0], exp_acc});
        @(negedge clk);
        check_v({tag, " R7 pulse"}, {dec_done, dec_mcast, dec_accept}, 3'b000);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: got run still active expected run complete");
        finish_run();
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check_v("R1 reset", {dec_done, dec_mcast, dec_accept}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check_v("R1 after reset", {dec_done, dec_mcast, dec_accept}, 3'b000);

        // R1: enable only; reset table of zeros must reject
        cfg_write(2'd2, 32'h1);
        send_addr(48'h0000_5E00_0001, 0, -1, 2'd0, 32'h0, "R1 zero table");

        // R5: all ones + enable accepts any group address
        load_table({64{1'b1}});
        send_addr(48'h0100_5E00_0001, 0, -1, 2'd0, 32'h0, "R5 all ones");
        send_addr(48'hFFFF_FFFF_FFFF, 1, -1, 2'd0, 32'h0, "R5 broadcast");
        send_addr(48'h3322_1100_0033, 0, -1, 2'd0, 32'h0, "R5 ipv6 group");

        // R6: individual address never accepted
        send_addr(48'h5544_3322_1100, 0, -1, 2'd0, 32'h0, "R6 individual");

        // R4: enable off rejects all
        cfg_write(2'd2, 32'h0);
        send_addr(48'h0100_5E00_0001, 0, -1, 2'd0, 32'h0, "R4 disabled");
        send_addr(48'hFFFF_FFFF_FFFF, 0, -1, 2'd0, 32'h0, "R4 disabled bcast");

        // R3: single bit, right word then wrong word
        cfg_write(2'd2, 32'h1);
        a  = 48'h0700_5E00_0001;
        ix = ref_idx(a);
        load_table(64'h1 << ix);
        send_addr(a, 0, -1, 2'd0, 32'h0, "R3 R2 right word");
        if (dec_accept !== 1'b0) ;
        load_table(64'h1 << (ix ^ 6'h20));
        send_addr(a, 0, -1, 2'd0, 32'h0, "R3 other word");
        load_table(64'h1 << (ix ^ 6'h01));
        send_addr(a, 0, -1, 2'd0, 32'h0, "R3 neighbour bit");

        // R10: write during address only applies to the next one
        load_table(64'h0);
        send_addr(a, 0, 3, ix[5] ? 2'd1 : 2'd0, 32'hFFFFFFFF, "R10 mid write");
        send_addr(a, 0, -1, 2'd0, 32'h0, "R10 next address");
        load_table(64'h0);
        send_addr(a, 0, 0, ix[5] ? 2'd1 : 2'd0, 32'hFFFFFFFF, "R10 write on start");
        send_addr(a, 0, 0, 2'd2, 32'h0, "R10 enable off on start");
        send_addr(a, 0, -1, 2'd0, 32'h0, "R10 enable off seen");
        cfg_write(2'd2, 32'h1);
        load_table(64'h0);
        cfg_write(2'd3, 32'hFFFFFFFF);
        send_addr(a, 0, -1, 2'd0, 32'h0, "R10 select 3 ignored");

        // R8: abort with a new start mid-address
        load_table({64{1'b1}});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            addr_valid = 1'b1; addr_start = (i == 0); addr_byte = 8'h02 + 8'(i);
        end
        send_addr(48'h0100_5E7F_FFFA, 0, -1, 2'd0, 32'h0, "R8 restart group");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            addr_valid = 1'b1; addr_start = (i == 0); addr_byte = 8'h01;
        end
        send_addr(48'h0A0B_0C0D_0E10, 0, -1, 2'd0, 32'h0, "R8 restart individual");

        // R9: stray bytes and start without valid are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_v("R9 stray bytes", {dec_done, dec_mcast, dec_accept}, 3'b000);
            addr_valid = 1'b1; addr_start = 1'b0; addr_byte = 8'(i) | 8'h01;
        end
        @(negedge clk);
        addr_valid = 1'b0; addr_start = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            check_v("R9 start without valid", {dec_done, dec_mcast, dec_accept}, 3'b000);
            addr_start = 1'b0; addr_valid = (i < 6); addr_byte = 8'h11;
        end
        @(negedge clk);
        check_v("R9 no report", {dec_done, dec_mcast, dec_accept}, 3'b000);

        // Random mix over R2, R3, R4, R5, R6, R9, R10
        for (int n = 0; n < 300; n++) begin
            logic [47:0] ra;
            int          wat;
            if ($urandom_range(3, 0) == 0)
                load_table({$urandom(), $urandom()});
            if ($urandom_range(7, 0) == 0)
                cfg_write(2'd2, {31'h0, ($urandom_range(3, 0) != 0)});
            ra  = {$urandom(), $urandom()} ;
            wat = ($urandom_range(3, 0) == 0) ? int'($urandom_range(5, 0)) : -1;
            send_addr(ra, 2, wat, 2'($urandom_range(3, 0)), $urandom(), "R2 R3 random");
        end

        finish_run();
    end

endmodule